// File: doc/BRIEF.md
# Integer ALU Slice with Status-Word Update

This block is one execution slice of an integer pipeline. Each accepted operation takes two 32-bit operands, an operation code and the current 32-bit status word. One clock later the block presents the operation result, a write-enable for the destination register and the new status word. Six status bits are recomputed: carry, parity, nibble carry, zero, sign and overflow. The other bits either keep fixed reserved values or pass through unchanged from the incoming word.

The supported operations are addition, subtraction, compare, bitwise AND, bit test and increment. Compare works like subtraction and bit test works like AND, but neither asks for the result to be written back. Increment recomputes five status bits and leaves the carry bit as it was. That is what lets a loop counter be stepped without losing a pending carry. The surrounding pipeline feeds the registered status word back as the next operation's incoming word.

Top module: `flagalu_top`

## Requirements
- R1: Reset state. While reset is low and after it is released, before any operation: `out_valid` and `result_we` are 0, `result` is 0 and `flags_out` is 0x202.
- R2: Reserved bits. In every status word the block presents, bit 1 is 1 and bits 3 and 5 are 0, whatever `flags_in` carries in those positions.
- R3: Addition (op 0) status bits:
  - bit 0 (carry) is the carry out of result bit 31.
  - bit 4 (nibble carry) is the carry from bit 3 into bit 4.
  - bit 11 (overflow) is set when both operands have the same sign and the result sign differs.
  - With `flags_in` = 0x202: 0xFFFFFFFF+0x80000000 gives 0xA07, 1+0x7FFFFFFF gives 0xA96, and 1+0xF gives 0x212.
- R4: Subtraction (op 1) and compare (op 2) compute a−b.
  - Bit 0 is the borrow out of bit 31.
  - Bit 4 is the borrow into bit 4.
  - Bit 11 is set when the operand signs differ and the result sign differs from a's sign.
  - With `flags_in` = 0x202: 0−1 gives 0x297, 0x80000000−1 gives 0xA16, and 0x7FFFFF00−0xFFFFFFF0 gives 0x203.
- R5: For every operation code from 0 to 5:
  - bit 2 is set when result bits 7:0 hold an even number of ones.
  - bit 6 is set when the 32-bit result is zero.
  - bit 7 equals result bit 31.
- R6: AND (op 3) and bit test (op 4) compute a&b and clear bits 0, 4 and 11. A zero result with `flags_in` = 0x202 gives 0x246.
- R7: Increment (op 4'd5 encoded as 5) computes a+1.
  - Bits 2, 4, 6, 7 and 11 follow the addition rules.
  - Bit 0 keeps the value of `flags_in` bit 0, including when the result wraps from 0xFFFFFFFF to 0.
- R8: Write-back. `result_we` is 1 for op codes 0, 1, 3 and 5, and 0 for op codes 2 and 4. `result` carries the computed value for all six codes.
- R9: Pass-through. Status bits 8, 9, 10 and 31:12 equal the corresponding bits of `flags_in` of the accepted operation.
- R10: Timing and hold.
  - Outputs update on the first clock edge that samples `in_valid` high. `out_valid` is high for exactly that cycle.
  - `result_we` is high only together with `out_valid`.
  - Cycles without `in_valid` leave `result` and `flags_out` unchanged.
- R11: Op codes 6 and 7 produce:
  - `out_valid` 1 and `result_we` 0;
  - `result` 0;
  - bits 0, 2, 4, 6, 7 and 11 copied from `flags_in`, with the reserved bits forced as in R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation accepted this cycle |
| op | input | 3 | Operation code (0 add, 1 sub, 2 cmp, 3 and, 4 test, 5 inc) |
| src_a | input | 32 | First operand |
| src_b | input | 32 | Second operand (ignored by increment) |
| flags_in | input | 32 | Current status word |
| out_valid | output | 1 | Registered outputs belong to a new operation |
| result | output | 32 | Operation result |
| result_we | output | 1 | Destination write-back request |
| flags_out | output | 32 | Updated status word |

## Verification
Every internal decision lands in a register one cycle after acceptance, so any fault is visible at the ports on the very next `out_valid` cycle. A wrong carry or borrow selection shows up as bit 0 or bit 4 disagreeing with the independent arithmetic model. A mis-decoded operation shows up as a wrong `result_we` or as uncleared carry and overflow bits on logic operations. A faulty merge stage shows up as corrupted pass-through or reserved bits. A capture-enable fault shows up as `flags_out` drifting during idle cycles.

// File: rtl/flagalu_pkg.sv
package flagalu_pkg;

  localparam int FLAGS_W = 32;

  localparam int FB_CARRY  = 0;
  localparam int FB_ONE    = 1;
  localparam int FB_PARITY = 2;
  localparam int FB_ZERO3  = 3;
  localparam int FB_NIBBLE = 4;
  localparam int FB_ZERO5  = 5;
  localparam int FB_ZF     = 6;
  localparam int FB_SIGN   = 7;
  localparam int FB_OVF    = 11;

  localparam logic [FLAGS_W-1:0] FLAGS_RESET = 32'h0000_0202;

  typedef enum logic [2:0] {
    OPC_ADD  = 3'd0,
    OPC_SUB  = 3'd1,
    OPC_CMP  = 3'd2,
    OPC_AND  = 3'd3,
    OPC_TEST = 3'd4,
    OPC_INC  = 3'd5
  } opc_e;

  // Even number of ones in the low byte.
  function automatic logic low_byte_even(input logic [7:0] v);
    return ~^v;
  endfunction

  // Carry or borrow across the bit-3/bit-4 boundary, recovered from the operands and the sum.
  function automatic logic nibble_cross(input logic [4:0] a, input logic [4:0] b, input logic [4:0] r);
    logic [4:0] t;
    t = a ^ b ^ r;
    return t[4];
  endfunction

  // Signed overflow from the top bits; for subtraction b is the original subtrahend.
  function automatic logic signed_ovf(input logic sub, input logic a_msb, input logic b_msb, input logic r_msb);
    return ((a_msb ^ b_msb) == sub) && (r_msb != a_msb);
  endfunction

endpackage

// File: rtl/flagalu_addsub.sv
module flagalu_addsub
  import flagalu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             sub,
  output logic [WIDTH-1:0] sum,
  output logic             carry,
  output logic             aux,
  output logic             ovf
);
  localparam int EXT_W = WIDTH + 1;

  logic [WIDTH-1:0] b_eff;
  logic [EXT_W-1:0] ext_sum;

  assign b_eff   = sub ? ~b : b;
  assign ext_sum = {1'b0, a} + {1'b0, b_eff} + EXT_W'(sub);
  assign sum     = ext_sum[WIDTH-1:0];
  // For subtraction the raw carry is the inverse of the borrow.
  assign carry   = ext_sum[WIDTH] ^ sub;
  assign aux     = nibble_cross(a[4:0], b[4:0], sum[4:0]);
  assign ovf     = signed_ovf(sub, a[WIDTH-1], b[WIDTH-1], sum[WIDTH-1]);
endmodule

// File: rtl/flagalu_merge.sv
module flagalu_merge
  import flagalu_pkg::*;
(
  input  logic [FLAGS_W-1:0] base,
  input  logic               upd,
  input  logic               cf,
  input  logic               pf,
  input  logic               af,
  input  logic               zf,
  input  logic               sf,
  input  logic               of,
  output logic [FLAGS_W-1:0] merged
);
  always_comb begin
    merged = base;
    if (upd) begin
      merged[FB_CARRY]  = cf;
      merged[FB_PARITY] = pf;
      merged[FB_NIBBLE] = af;
      merged[FB_ZF]     = zf;
      merged[FB_SIGN]   = sf;
      merged[FB_OVF]    = of;
    end
    merged[FB_ONE]   = 1'b1;
    merged[FB_ZERO3] = 1'b0;
    merged[FB_ZERO5] = 1'b0;
  end
endmodule

// File: rtl/flagalu_top.sv
module flagalu_top
  import flagalu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [2:0]         op,
  input  logic [WIDTH-1:0]   src_a,
  input  logic [WIDTH-1:0]   src_b,
  input  logic [FLAGS_W-1:0] flags_in,
  output logic               out_valid,
  output logic [WIDTH-1:0]   result,
  output logic               result_we,
  output logic [FLAGS_W-1:0] flags_out
);
  opc_e op_sel;
  logic is_sub, is_inc, is_logic, is_arith, legal, writes;

  assign op_sel   = opc_e'(op);
  assign is_sub   = (op_sel == OPC_SUB) || (op_sel == OPC_CMP);
  assign is_inc   = (op_sel == OPC_INC);
  assign is_logic = (op_sel == OPC_AND) || (op_sel == OPC_TEST);
  assign is_arith = (op_sel == OPC_ADD) || is_sub || is_inc;
  assign legal    = is_arith || is_logic;
  assign writes   = (op_sel == OPC_ADD) || (op_sel == OPC_SUB) ||
                    (op_sel == OPC_AND) || is_inc;

  logic [WIDTH-1:0] addend, as_res, and_res, next_res;
  logic             as_cf, as_af, as_of;

  assign addend = is_inc ? WIDTH'(1) : src_b;

  flagalu_addsub #(.WIDTH(WIDTH)) u_addsub (
    .a(src_a), .b(addend), .sub(is_sub),
    .sum(as_res), .carry(as_cf), .aux(as_af), .ovf(as_of)
  );

  assign and_res  = src_a & src_b;
  assign next_res = is_logic ? and_res : (is_arith ? as_res : '0);

  // Named status events, visible to the checker.
  logic carry_evt, parity_evt, nibble_evt, zero_evt, sign_evt, ovf_evt;
  assign carry_evt  = is_inc ? flags_in[FB_CARRY] : (is_arith & as_cf);
  assign parity_evt = low_byte_even(next_res[7:0]);
  assign nibble_evt = is_arith & as_af;
  assign zero_evt   = (next_res == '0);
  assign sign_evt   = next_res[WIDTH-1];
  assign ovf_evt    = is_arith & as_of;

  logic [FLAGS_W-1:0] next_flags;

  flagalu_merge u_merge (
    .base(flags_in), .upd(legal),
    .cf(carry_evt), .pf(parity_evt), .af(nibble_evt),
    .zf(zero_evt), .sf(sign_evt), .of(ovf_evt),
    .merged(next_flags)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result_we <= 1'b0;
      result    <= '0;
      flags_out <= FLAGS_RESET;
    end else begin
      out_valid <= in_valid;
      result_we <= in_valid & writes;
      if (in_valid) begin
        result    <= next_res;
        flags_out <= next_flags;
      end
    end
  end
endmodule

// File: rtl/flagalu_chk.sv
module flagalu_chk
  import flagalu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic [2:0]         op,
  input logic [FLAGS_W-1:0] flags_in,
  input logic               out_valid,
  input logic [WIDTH-1:0]   result,
  input logic               result_we,
  input logic [FLAGS_W-1:0] flags_out,
  input logic               carry_evt
);
  a_r2_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    flags_out[FB_ONE] && !flags_out[FB_ZERO3] && !flags_out[FB_ZERO5]);

  a_r5_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(op) < 3'd6) |-> (flags_out[FB_ZF] == (result == '0)));

  a_r5_sign: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(op) < 3'd6) |-> (flags_out[FB_SIGN] == result[WIDTH-1]));

  a_r5_parity: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(op) < 3'd6) |-> (flags_out[FB_PARITY] == ~^result[7:0]));

  a_r6_logic_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && ($past(op) == 3'd3 || $past(op) == 3'd4)) |->
      (!flags_out[FB_CARRY] && !flags_out[FB_NIBBLE] && !flags_out[FB_OVF]));

  a_r7_inc_keeps_carry: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(op) == 3'd5) |-> (flags_out[FB_CARRY] == $past(flags_in[FB_CARRY])));

  a_r3_carry_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(op) < 3'd6) |-> (flags_out[FB_CARRY] == $past(carry_evt)));

  a_r8_no_writeback: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && ($past(op) == 3'd2 || $past(op) == 3'd4)) |-> !result_we);

  a_r9_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (flags_out[10:8] == $past(flags_in[10:8]) &&
                   flags_out[31:12] == $past(flags_in[31:12])));

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(flags_out) && $stable(result)));

  a_r10_we_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
    result_we |-> out_valid);

  a_r11_illegal: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(op) >= 3'd6) |->
      (!result_we && result == '0 && flags_out[FB_OVF] == $past(flags_in[FB_OVF])));
endmodule

bind flagalu_top flagalu_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/flagalu_top_tb.sv
module flagalu_top_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [2:0]  op = 3'd0;
  logic [31:0] src_a = '0, src_b = '0, flags_in = 32'h202;
  logic        out_valid, result_we;
  logic [31:0] result, flags_out;

  int n_checks = 0;
  int n_bad = 0;

  typedef struct {
    logic [31:0] res;
    logic        we;
    logic [31:0] flg;
    string       tag;
  } exp_t;

  exp_t exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  flagalu_top u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
    .src_a(src_a), .src_b(src_b), .flags_in(flags_in),
    .out_valid(out_valid), .result(result), .result_we(result_we),
    .flags_out(flags_out)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic even_ones(input logic [7:0] v);
    int c = 0;
    for (int i = 0; i < 8; i++) c += int'(v[i]);
    return (c % 2) == 0;
  endfunction

  // Behavioural model written from the requirements.
  function automatic void model(input logic [2:0] o, input logic [31:0] a, input logic [31:0] b,
                                input logic [31:0] fin, output logic [31:0] r,
                                output logic w, output logic [31:0] f);
    longint sa, sb, sr;
    longint unsigned ua, ub;
    logic cf, af, ovf, keep;
    f = fin; r = '0; cf = 0; af = 0; ovf = 0; keep = 0;
    sa = longint'($signed(a));
    ua = longint'(a);
    if (o == 3'd5) begin sb = 1; ub = 1; end
    else begin sb = longint'($signed(b)); ub = longint'(b); end
    case (o)
      3'd0, 3'd5: begin
        r   = 32'(ua + ub);
        cf  = (o == 3'd5) ? fin[0] : ((ua + ub) > 64'hFFFF_FFFF);
        af  = (int'(a[3:0]) + int'(ub[3:0])) > 15;
        sr  = sa + sb;
        ovf = (sr > 64'sd2147483647) || (sr < -64'sd2147483648);
      end
      3'd1, 3'd2: begin
        r   = a - b;
        cf  = a < b;
        af  = a[3:0] < b[3:0];
        sr  = sa - sb;
        ovf = (sr > 64'sd2147483647) || (sr < -64'sd2147483648);
      end
      3'd3, 3'd4: r = a & b;
      default: keep = 1;
    endcase
    if (!keep) begin
      f[0] = cf; f[2] = even_ones(r[7:0]); f[4] = af;
      f[6] = (r == 0); f[7] = r[31]; f[11] = ovf;
    end
    f[1] = 1'b1; f[3] = 1'b0; f[5] = 1'b0;
    w = (o == 3'd0) || (o == 3'd1) || (o == 3'd3) || (o == 3'd5);
  endfunction

  function automatic string tag_of(input logic [2:0] o);
    case (o)
      3'd0: return "R3 R5 R2 R9";
      3'd1, 3'd2: return "R4 R5 R2 R9";
      3'd3, 3'd4: return "R6 R5 R2 R9";
      3'd5: return "R7 R5 R2 R9";
      default: return "R11 R2 R9";
    endcase
  endfunction

  // Driver: called at a falling edge, returns at the next falling edge.
  task automatic drive(input logic [2:0] o, input logic [31:0] a, input logic [31:0] b,
                       input logic [31:0] fin, input bit use_ref, input logic [31:0] ref_flg);
    exp_t e;
    model(o, a, b, fin, e.res, e.we, e.flg);
    if (use_ref) e.flg = ref_flg;
    e.tag = tag_of(o);
    exp_q.push_back(e);
    op = o; src_a = a; src_b = b; flags_in = fin; in_valid = 1'b1;
    @(negedge clk);
  endtask

  // Monitor / scoreboard.
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R10 unexpected out_valid", 32'(out_valid), 32'd0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(result == e.res, "R8 result", result, e.res);
        check(result_we == e.we, "R8 result_we", 32'(result_we), 32'(e.we));
        check(flags_out == e.flg, e.tag, flags_out, e.flg);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    n_checks++; n_bad++;
    $display("FAIL watchdog: actual=%0d expected=%0d", exp_q.size(), 0);
    $display("test done: total=%0d bad=%0d", n_checks, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] hold_f, hold_r;
    logic [31:0] corner [8];
    corner[0] = 32'h0;        corner[1] = 32'h1;        corner[2] = 32'hFFFF_FFFF;
    corner[3] = 32'h8000_0000; corner[4] = 32'h7FFF_FFFF; corner[5] = 32'hF;
    corner[6] = 32'hFFFF_FFF0; corner[7] = 32'h10;

    repeat (3) @(negedge clk);
    // R1: reset state
    check(out_valid == 0 && result_we == 0, "R1 valid/we", {30'd0, out_valid, result_we}, 32'd0);
    check(result == 0, "R1 result", result, 32'd0);
    check(flags_out == 32'h202, "R1 flags", flags_out, 32'h202);
    rst_n = 1'b1;
    @(negedge clk);
    check(flags_out == 32'h202 && !out_valid, "R1 after release", flags_out, 32'h202);

    // R3 reference vectors
    drive(3'd0, 32'hFFFF_FFFF, 32'h8000_0000, 32'h202, 1, 32'hA07);
    drive(3'd0, 32'h1, 32'h7FFF_FFFF, 32'h202, 1, 32'hA96);
    drive(3'd0, 32'h1, 32'hF, 32'h202, 1, 32'h212);
    drive(3'd0, 32'h0, 32'h0, 32'h202, 1, 32'h246);
    // R4 reference vectors, both subtract and compare
    drive(3'd1, 32'h0, 32'h1, 32'h202, 1, 32'h297);
    drive(3'd2, 32'h8000_0000, 32'h1, 32'h202, 1, 32'hA16);
    drive(3'd1, 32'h7FFF_FF00, 32'hFFFF_FFF0, 32'h202, 1, 32'h203);
    drive(3'd2, 32'h0, 32'h1, 32'h202, 1, 32'h297);
    // R6 logic ops
    drive(3'd4, 32'h1, 32'h0, 32'h202, 1, 32'h246);
    drive(3'd3, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hA13, 1, 32'h286);
    // R7 increment keeps carry across wrap
    drive(3'd5, 32'hFFFF_FFFF, 32'h0, 32'h203, 1, 32'h257);
    drive(3'd5, 32'hFFFF_FFFF, 32'h0, 32'h202, 1, 32'h256);
    drive(3'd5, 32'h7FFF_FFFF, 32'h0, 32'h203, 1, 32'hA97);
    // R2 R9 R11: hostile incoming word, illegal codes
    drive(3'd6, 32'h1234, 32'h5678, 32'hFFFF_FFFF, 1, 32'hFFFF_FFD7);
    drive(3'd7, 32'h1, 32'h1, 32'h0000_0000, 1, 32'h0000_0002);
    drive(3'd0, 32'h5, 32'h6, 32'hFFFF_F7FF, 0, 32'h0);

    // Random and corner mix
    for (int i = 0; i < 400; i++) begin
      logic [31:0] ra, rb;
      ra = (i % 3 == 0) ? corner[$urandom_range(7)] : $urandom();
      rb = (i % 4 == 0) ? corner[$urandom_range(7)] : $urandom();
      drive(3'($urandom_range(7)), ra, rb, $urandom(), 0, 32'h0);
      if (i % 17 == 0) begin
        in_valid = 1'b0;
        @(negedge clk);
      end
    end

    // R10: idle cycles hold the outputs
    in_valid = 1'b0;
    @(negedge clk);
    hold_f = flags_out; hold_r = result;
    for (int k = 0; k < 4; k++) begin
      op = 3'd0; src_a = $urandom(); src_b = $urandom(); flags_in = $urandom();
      @(negedge clk);
      check(flags_out == hold_f, "R10 flags hold", flags_out, hold_f);
      check(result == hold_r, "R10 result hold", result, hold_r);
      check(!out_valid && !result_we, "R10 idle strobes", {30'd0, out_valid, result_we}, 32'd0);
    end
    check(exp_q.size() == 0, "R10 queue drained", 32'(exp_q.size()), 32'd0);

    $display("test done: total=%0d bad=%0d", n_checks, n_bad);
    $finish;
  end
endmodule